// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Decoder

This block samples the row strobe, the two byte-lane column strobes, the write enable and the output enable of an asynchronous EDO DRAM interface on a fast system clock. From the order in which those strobes change, it decides what kind of DRAM cycle is in progress. It latches the row and column addresses and reports the cycle class as a three-bit code. It also raises a one-cycle write strobe for each byte lane and decides, lane by lane, whether the data pins would be driven. A small parameterised word array sits behind the decoder. The block can therefore serve as the control and storage core of a behavioural memory stand-in, and its violation output makes it usable as a protocol monitor.

All strobes are active low. Every output is registered. An event seen on a sample becomes visible on the outputs after the clock edge that took that sample. Timing finer than one clock period is not checked. Lane 0 is the lower byte: it uses the lower column strobe and data bits [7:0]. Lane 1 is the upper byte: it uses the upper column strobe and bits [15:8].

Top module: `edo_cycle_decoder`

## Requirements
- R1: If either column strobe is sampled low on the sample where the row strobe falls, the cycle code becomes 5 (CAS-before-RAS refresh). No lane write strobe fires and no lane is driven for the rest of that row cycle.
- R2: If the row strobe falls with both column strobes high, the row output takes the address. If the row strobe then rises with no column access in between, the cycle code becomes 6 (RAS-only refresh).
- R3: If write enable is low on the first column strobe fall of an access, the code becomes 2 (early write). The addressed lanes are written and no lane is driven.
- R4: If write enable is high at the column fall, the code is 1 (read). A later write-enable fall with a column strobe low writes the data. The code becomes 4 (read-modify-write) if a lane was being driven at that moment, and 3 (delayed write) otherwise.
- R5: Writes and output drive are per lane. A lane is written (its bit of the write strobe pulses for one cycle) or driven only if its own column strobe is low.
- R6: A read returns the stored word on the strobed lanes. The drive decision persists while the column strobes are high and the row strobe is low. It is cleared only once the row strobe and both column strobes are all sampled high, whichever of them rises last.
- R7: Drive requires output enable low. An output-enable rise while both column strobes are high, or any write-enable fall, clears the drive. Drive does not return until the next column access.
- R8: A refresh-by-column-first cycle that holds the row strobe and both column strobes low for SR_CYC samples changes the code to 7 (self refresh).
- R9: A column strobe that falls while the other lane's strobe was already low from an earlier sample (staggered lanes) pulses the violation output for one cycle. Simultaneous falls raise nothing.
- R10: The violation output pulses once the row strobe has been low for more than RAS_MAX samples in a cycle that is not a refresh-by-column-first or self-refresh cycle. It does not pulse before that point.
- R11: After reset the code is 0 (standby), and the write strobes, drive decisions and violation output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | 2*BYTE_W | Write data |
| op | output | 3 | Cycle class code |
| wr_lane | output | 2 | One-cycle write strobe per lane |
| row | output | ROW_W | Latched row |
| col | output | COL_W | Latched column |
| dout | output | 2*BYTE_W | Read data, held between accesses |
| dq_oe | output | 2 | Per-lane drive decision |
| violation | output | 1 | Protocol violation pulse |

## Verification
The hardest cases depend on strobe order across several samples. Read-modify-write differs from delayed write only in whether a lane is already driving when write enable falls. The drive-kill rules differ depending on whether the column strobes are high or low. The stimulus reaches these states by stepping the strobes one sample at a time on the inactive clock edge. It lets the read drive establish itself, or holds output enable high, before dropping write enable. The self-refresh and long-row limits use small parameter overrides, so the bench reaches them in a few hundred cycles.

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder #(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int BYTE_W  = 8,
  parameter int SR_CYC  = 25000,
  parameter int RAS_MAX = 2500
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ras_n,
  input  logic                       ucas_n,
  input  logic                       lcas_n,
  input  logic                       we_n,
  input  logic                       oe_n,
  input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  input  logic [2*BYTE_W-1:0]        din,
  output logic [2:0]                 op,
  output logic [1:0]                 wr_lane,
  output logic [ROW_W-1:0]           row,
  output logic [COL_W-1:0]           col,
  output logic [2*BYTE_W-1:0]        dout,
  output logic [1:0]                 dq_oe,
  output logic                       violation
);
  localparam int DW    = 2 * BYTE_W;
  localparam int MW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << MW;
  localparam int CMAX  = (SR_CYC > RAS_MAX) ? SR_CYC : RAS_MAX;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SR_L   = CW'(SR_CYC);
  localparam logic [CW-1:0] RMAX_L = CW'(RAS_MAX);
  localparam logic [CW-1:0] CMAX_L = CW'(CMAX);

  localparam logic [2:0] OP_STBY = 3'd0, OP_READ = 3'd1, OP_EWR = 3'd2, OP_DWR = 3'd3,
                         OP_RMW  = 3'd4, OP_CBR  = 3'd5, OP_RONLY = 3'd6, OP_SELF = 3'd7;

  logic          ras_q, we_q, oe_q;
  logic [1:0]    cas_q;
  logic [1:0]    valid;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];

  wire [1:0] cas_lo    = {~ucas_n, ~lcas_n};
  wire [1:0] cas_lo_q  = ~cas_q;
  wire [1:0] lane_fall = cas_lo & ~cas_lo_q;
  wire       any_fall  = (|cas_lo) & ~(|cas_lo_q);
  wire       ras_fall  = ras_q & ~ras_n;
  wire       ras_rise  = ~ras_q & ras_n;
  wire       we_fall   = we_q & ~we_n;
  wire       oe_rise   = ~oe_q & oe_n;
  wire       refr      = (op == OP_CBR) || (op == OP_SELF);
  wire       acc       = ~ras_n & ~ras_q & ~refr;
  wire       idle      = ras_n & ucas_n & lcas_n;
  wire       stagger   = (lane_fall[0] & cas_lo_q[1]) | (lane_fall[1] & cas_lo_q[0]);
  wire [MW-1:0] ra     = {row, addr[COL_W-1:0]};

  logic [1:0]    wr_ev, rd_ev;
  logic [MW-1:0] wa [2];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      wr_ev[i] = acc & ((lane_fall[i] & ~we_n) | (we_fall & cas_lo[i]));
      rd_ev[i] = acc & lane_fall[i] & we_n;
      wa[i]    = {row, lane_fall[i] ? addr[COL_W-1:0] : col};
    end
  end

  assign dq_oe = valid & {2{~oe_q}};

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++)
      if (wr_ev[i]) mem[wa[i]][i*BYTE_W +: BYTE_W] <= din[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1; we_q <= 1'b1; oe_q <= 1'b1; cas_q <= 2'b11;
      op <= OP_STBY; wr_lane <= '0; row <= '0; col <= '0; dout <= '0;
      valid <= '0; cnt <= '0; violation <= 1'b0;
    end else begin
      ras_q <= ras_n; we_q <= we_n; oe_q <= oe_n; cas_q <= {ucas_n, lcas_n};
      wr_lane <= wr_ev;

      if (ras_n) cnt <= '0;
      else if (cnt != CMAX_L) cnt <= cnt + 1'b1;

      violation <= (acc & stagger) | (~ras_n & ~refr & (cnt == RMAX_L));

      if (ras_fall) begin
        op <= (|cas_lo) ? OP_CBR : OP_STBY;
        if (~|cas_lo) row <= addr[ROW_W-1:0];
      end else if (ras_rise && op == OP_STBY)
        op <= OP_RONLY;
      else if (acc && any_fall)
        op <= we_n ? OP_READ : OP_EWR;
      else if (acc && we_fall && op == OP_READ && |cas_lo)
        op <= (|dq_oe) ? OP_RMW : OP_DWR;
      else if (op == OP_CBR && ~ras_n && &cas_lo && cnt == SR_L)
        op <= OP_SELF;

      if (acc && |lane_fall) col <= addr[COL_W-1:0];

      for (int i = 0; i < 2; i++)
        if (rd_ev[i]) dout[i*BYTE_W +: BYTE_W] <= mem[ra][i*BYTE_W +: BYTE_W];

      if (idle || we_fall || (oe_rise && ~|cas_lo))
        valid <= '0;
      else
        for (int i = 0; i < 2; i++)
          if (acc && lane_fall[i]) valid[i] <= we_n;
          else if (acc && any_fall && !cas_lo[i]) valid[i] <= 1'b0;
    end
  end

  AST_CBR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CBR |-> wr_lane == 2'b00); // R1
  AST_EARLY_WR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && any_fall && !we_n) |=> dq_oe == 2'b00); // R3
  AST_LANE_LO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane[0] |-> $past(!lcas_n)); // R5
  AST_LANE_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane[1] |-> $past(!ucas_n)); // R5
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && ucas_n && lcas_n) |=> dq_oe == 2'b00); // R6
  AST_WE_FALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && !we_n) |=> dq_oe == 2'b00); // R7
endmodule

// File: tb/test_edo_cycle_decoder.sv
module test_edo_cycle_decoder;
  localparam int ROW_W = 4, COL_W = 4, BYTE_W = 8, SR_CYC = 120, RAS_MAX = 40;
  localparam int DW = 2 * BYTE_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [2:0] op;
  logic [1:0] wr_lane, dq_oe;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [DW-1:0] dout;
  logic violation;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [256];

  always #2 clk = ~clk;

  edo_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .BYTE_W(BYTE_W),
    .SR_CYC(SR_CYC), .RAS_MAX(RAS_MAX)) i_edo_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .op(op), .wr_lane(wr_lane),
    .row(row), .col(col), .dout(dout), .dq_oe(dq_oe), .violation(violation));

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] lanes);
    return {{BYTE_W{lanes[1]}}, {BYTE_W{lanes[0]}}};
  endfunction

  task automatic open_row(input logic [3:0] r);
    addr = r; ras_n = 1'b0; step();
  endtask

  task automatic close_all();
    ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step();
    ras_n = 1'b1; step(2);
  endtask

  task automatic t_reset();
    chk("R11 op", op, 3'd0);
    chk("R11 wr_lane", wr_lane, 2'b00);
    chk("R11 dq_oe", dq_oe, 2'b00);
    chk("R11 violation", violation, 1'b0);
  endtask

  task automatic t_early_write(input logic [3:0] r, input logic [3:0] c,
                               input logic [DW-1:0] d, input logic [1:0] lanes);
    logic [DW-1:0] m = lane_mask(lanes);
    open_row(r);
    addr = c; we_n = 1'b0; oe_n = 1'b0; din = d;
    lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; step();
    chk("R3 op early write", op, 3'd2);
    chk("R5 lane write strobe", wr_lane, lanes);
    chk("R3 no drive", dq_oe, 2'b00);
    exp_mem[{r, c}] = (exp_mem[{r, c}] & ~m) | (d & m);
    step();
    chk("R5 strobe one cycle", wr_lane, 2'b00);
    close_all();
  endtask

  task automatic t_read(input logic [3:0] r, input logic [3:0] c, input logic [1:0] lanes);
    logic [DW-1:0] m = lane_mask(lanes);
    open_row(r);
    addr = c; oe_n = 1'b0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; step();
    chk("R4 op read", op, 3'd1);
    chk("R5 lane drive", dq_oe, lanes);
    chk("R6 read data", dout & m, exp_mem[{r, c}] & m);
    chk("R6 column latch", col, c);
    ucas_n = 1'b1; lcas_n = 1'b1; step();
    chk("R6 hold while CAS high", dq_oe, lanes);
    ras_n = 1'b1; step();
    chk("R6 off after all high", dq_oe, 2'b00);
    oe_n = 1'b1; step(2);
  endtask

  task automatic t_ras_first(input logic [3:0] r, input logic [3:0] c);
    open_row(r);
    addr = c; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step();
    ras_n = 1'b1; step();
    chk("R6 held with CAS low after RAS rise", dq_oe, 2'b11);
    lcas_n = 1'b1; ucas_n = 1'b1; step();
    chk("R6 off after later CAS rise", dq_oe, 2'b00);
    oe_n = 1'b1; step(2);
  endtask

  task automatic t_kill(input logic [3:0] r, input logic [3:0] c);
    open_row(r);
    addr = c; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step();
    lcas_n = 1'b1; ucas_n = 1'b1; step();
    oe_n = 1'b1; step();
    chk("R7 OE rise with CAS high", dq_oe, 2'b00);
    oe_n = 1'b0; step();
    chk("R7 stays off until next access", dq_oe, 2'b00);
    lcas_n = 1'b0; ucas_n = 1'b0; step();
    chk("R7 next access drives", dq_oe, 2'b11);
    lcas_n = 1'b1; ucas_n = 1'b1; step();
    we_n = 1'b0; step();
    chk("R7 WE fall with CAS high", dq_oe, 2'b00);
    we_n = 1'b1; step();
    chk("R7 still off after WE returns", dq_oe, 2'b00);
    close_all();
  endtask

  task automatic t_delayed(input logic [3:0] r, input logic [3:0] c, input logic [DW-1:0] d);
    open_row(r);
    addr = c; oe_n = 1'b1; lcas_n = 1'b0; ucas_n = 1'b0; step();
    chk("R4 read before WE", op, 3'd1);
    chk("R7 OE high no drive", dq_oe, 2'b00);
    we_n = 1'b0; din = d; step();
    chk("R4 op delayed write", op, 3'd3);
    chk("R4 delayed write strobe", wr_lane, 2'b11);
    exp_mem[{r, c}] = d;
    close_all();
  endtask

  task automatic t_rmw(input logic [3:0] r, input logic [3:0] c, input logic [DW-1:0] d);
    open_row(r);
    addr = c; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step();
    chk("R4 rmw read part", dout, exp_mem[{r, c}]);
    chk("R4 rmw driving", dq_oe, 2'b11);
    we_n = 1'b0; din = d; step();
    chk("R4 op read-modify-write", op, 3'd4);
    chk("R4 rmw write strobe", wr_lane, 2'b11);
    exp_mem[{r, c}] = d;
    close_all();
  endtask

  task automatic t_cbr();
    bit bad = 0;
    lcas_n = 1'b0; step();
    we_n = 1'b0; ras_n = 1'b0; din = 16'hdead; step();
    chk("R1 op CBR", op, 3'd5);
    ucas_n = 1'b0; we_n = 1'b1; step();
    if (wr_lane != 2'b00 || dq_oe != 2'b00) bad = 1;
    we_n = 1'b0; oe_n = 1'b0; step();
    if (wr_lane != 2'b00 || dq_oe != 2'b00) bad = 1;
    step();
    if (wr_lane != 2'b00 || dq_oe != 2'b00) bad = 1;
    chk("R1 no write or drive in refresh", bad, 1'b0);
    close_all();
  endtask

  task automatic t_ras_only(input logic [3:0] r);
    open_row(r);
    chk("R2 row latched", row, r);
    step(3);
    ras_n = 1'b1; step();
    chk("R2 op RAS-only refresh", op, 3'd6);
    step();
  endtask

  task automatic t_stagger();
    open_row(4'h2);
    addr = 4'h1; oe_n = 1'b0; lcas_n = 1'b0; step();
    chk("R9 single fall ok", violation, 1'b0);
    ucas_n = 1'b0; step();
    chk("R9 staggered lanes", violation, 1'b1);
    step();
    chk("R9 pulse ends", violation, 1'b0);
    close_all();
    open_row(4'h2);
    addr = 4'h1; lcas_n = 1'b0; ucas_n = 1'b0; step();
    chk("R9 simultaneous no violation", violation, 1'b0);
    close_all();
  endtask

  task automatic t_ras_max();
    bit early = 0, seen = 0;
    open_row(4'h7);
    for (int k = 0; k < RAS_MAX - 3; k++) begin
      if (violation) early = 1;
      step();
    end
    chk("R10 no early violation", early, 1'b0);
    for (int k = 0; k < 12; k++) begin
      if (violation) seen = 1;
      step();
    end
    chk("R10 long RAS violation", seen, 1'b1);
    ras_n = 1'b1; step(2);
  endtask

  task automatic t_self();
    bit seen = 0;
    lcas_n = 1'b0; ucas_n = 1'b0; step();
    ras_n = 1'b0; step();
    for (int k = 0; k < SR_CYC / 2; k++) begin
      if (violation) seen = 1;
      step();
    end
    chk("R8 still CBR before limit", op, 3'd5);
    for (int k = 0; k < SR_CYC; k++) begin
      if (violation) seen = 1;
      step();
    end
    chk("R8 op self refresh", op, 3'd7);
    chk("R10 refresh exempt from limit", seen, 1'b0);
    close_all();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_early_write(4'h3, 4'h5, 16'h1234, 2'b11);
    t_read(4'h3, 4'h5, 2'b11);
    t_early_write(4'h3, 4'h5, 16'hbeef, 2'b01);
    t_read(4'h3, 4'h5, 2'b11);
    t_read(4'h3, 4'h5, 2'b10);
    t_early_write(4'ha, 4'h0, 16'h55aa, 2'b11);
    t_ras_first(4'ha, 4'h0);
    t_kill(4'ha, 4'h0);
    t_delayed(4'h6, 4'h9, 16'hc0de);
    t_read(4'h6, 4'h9, 2'b11);
    t_rmw(4'h6, 4'h9, 16'h7e57);
    t_read(4'h6, 4'h9, 2'b11);
    t_cbr();
    t_read(4'h6, 4'h9, 2'b11);
    t_ras_only(4'hd);
    t_stagger();
    t_ras_max();
    t_self();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule